// File: doc/BRIEF.md
# Two-Channel Capture/Compare Timer with Interlocked Flag Clearing

This block holds two timer channels that share one free-running up-counter. Each channel has a control byte, a value register, an event flag, an interrupt request and one pin. A channel in capture mode copies the counter into its value register when a chosen edge arrives on its pin. A channel in compare mode raises its flag when the counter equals its value register, and it can drive its pin on that match. Software reaches every register through a simple synchronous strobe bus. Register reads are combinational.

Each flag is cleared through a two-step handshake. Software first reads the control byte while the flag is 1, then writes 0 to the flag bit. A per-channel state machine keeps track of this. FL_IDLE means no flag. FL_PEND means the flag is up but no read has seen it. FL_ARMED means the flag is up and a read has seen it. The transitions are:
- set_flag: FL_IDLE goes to FL_PEND on an event.
- arm: FL_PEND goes to FL_ARMED on a control read with no event in that cycle.
- re_event: FL_ARMED goes back to FL_PEND on any new event.
- clear: FL_ARMED goes to FL_IDLE on a write with the flag bit at 0 and no event in that cycle.

Channel 0 also has a buffered compare mode. While it is on, channel 1 is switched off. Channel 0 then compares against whichever value register was written last, and it takes that value only when the counter wraps.

Top module: `tim_ccpair`

## Requirements
- R1: After reset, both control bytes and both value registers read 0, and every irq, pin_out and pin_oe bit is 0.
- R2: In capture mode (control bits 5 and 4 both 0), bits 3:2 select the active edge: 01 rising, 10 falling, 11 either edge, 00 no capture. The pin passes through two synchronizer flops and one edge flop. The flag sets on the third rising clock edge after the pin changes. In that same edge the value register takes the counter value that was present just before the edge.
- R3: In compare mode (bit 4 set, or bit 5 set on channel 0), the flag sets on the clock edge at which the counter held the compare value just before the edge.
- R4: A write of 0 to flag bit 7 clears the flag only after an earlier control read returned the flag as 1. Without that read, the write leaves the flag set.
- R5: A capture or compare event that lands after the arming read and before the zero write cancels the arming. That zero write then leaves the flag set, and a fresh read is needed.
- R6: Writing 1 to flag bit 7 never sets the flag. Bits 6:0 of the same write are still stored.
- R7: irq of a channel is 1 exactly while that channel's flag and interrupt enable (bit 6) are both 1.
- R8: In compare mode, bits 3:2 act on the pin at a match: 01 toggles it, 10 drives it low, 11 drives it high. pin_oe is 1 while the channel is enabled, in compare mode and bits 3:2 are not 00.
- R9: Bit 5 exists only in channel 0; in channel 1 it reads 0. While channel 0 bit 5 is 1:
  - writes and reads of channel 1's control byte have no effect;
  - channel 1 events are suppressed;
  - irq[1] and pin_oe[1] are held at 0.
- R10: In buffered mode, channel 0 keeps its active compare value until the counter passes from all-ones to zero. At that point it loads the value register (address 1 or 3) written most recently.
- R11: Control byte layout:

  | Bit | Field |
  |-----|-------|
  | 7 | flag |
  | 6 | interrupt enable |
  | 5 | buffered mode |
  | 4 | compare mode |
  | 3:2 | edge/action select |
  | 1 | spare, stored |
  | 0 | spare, stored |

  Address map: 0 channel 0 control, 1 channel 0 value, 2 channel 1 control, 3 channel 1 value, 4 counter. The control byte sits in the low 8 bits of the data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational |
| pin_in | input | 2 | Channel pin inputs |
| pin_out | output | 2 | Channel pin output values |
| pin_oe | output | 2 | Channel pin output enables |
| irq | output | 2 | Channel interrupt requests |

## Verification
A flag state machine stuck in FL_ARMED, or never reaching it, shows up at the very next zero write. Depending on the fault, irq either drops when it should hold or holds when it should drop, and the bench samples irq one cycle after each write. A wrong synchronizer depth or edge decode moves the flag by whole cycles or loses it. The bench catches this on the exact cycle the flag should set, and it also compares the captured value against the counter. Stale or wrongly selected buffered compare values show up as a flag at the wrong counter value, either before or after the wrap.

// File: rtl/tim_ccpair_pkg.sv
package tim_ccpair_pkg;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_PEND  = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_t;

    // control fields below the flag bit, most significant first
    typedef struct packed {
        logic       ie;
        logic       buf_mode;
        logic       cmp_mode;
        logic [1:0] sel;
        logic       spare1;
        logic       spare0;
    } chan_ctl_t;

    localparam int SC_FLAG = 7;
    localparam int SC_IE   = 6;
    localparam int SC_BUF  = 5;
    localparam int SC_CMP  = 4;
    localparam int SC_SELH = 3;
    localparam int SC_SELL = 2;

    localparam logic [1:0] SEL_OFF  = 2'b00;  // no capture / no pin action
    localparam logic [1:0] SEL_RISE = 2'b01;  // rising edge / toggle
    localparam logic [1:0] SEL_FALL = 2'b10;  // falling edge / drive low
    localparam logic [1:0] SEL_BOTH = 2'b11;  // either edge / drive high

    localparam logic [2:0] ADR_CNT = 3'd4;

endpackage

// File: rtl/tim_pin_edge.sv
module tim_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[TOP-1:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[TOP];
    end

    assign rise = sync_q[TOP] & ~last_q;
    assign fall = ~sync_q[TOP] & last_q;

endmodule

// File: rtl/tim_buf_cmp.sv
module tim_buf_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buffered,
    input  logic             wrap,
    input  logic [CNT_W-1:0] val0,
    input  logic [CNT_W-1:0] val1,
    input  logic             wr0,
    input  logic             wr1,
    output logic [CNT_W-1:0] cmp_val
);
    logic             last_one_q;
    logic [CNT_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   last_one_q <= 1'b0;
        else if (wr1) last_one_q <= 1'b1;
        else if (wr0) last_one_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         active_q <= '0;
        else if (!buffered) active_q <= val0;
        else if (wrap)      active_q <= last_one_q ? val1 : val0;
    end

    assign cmp_val = buffered ? active_q : val0;

endmodule

// File: rtl/tim_cc_chan.sv
module tim_cc_chan
    import tim_ccpair_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_BUF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] wdata,
    input  logic             sc_wr,
    input  logic             sc_rd,
    input  logic             val_wr,
    input  logic             rise,
    input  logic             fall,
    output logic [7:0]       sc_q,
    output logic [CNT_W-1:0] val_q,
    output logic             irq,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             buf_q,
    output logic             armed,
    output logic             flag,
    output logic             event_o
);
    chan_ctl_t        ctl_q, ctl_d;
    flag_state_t      fl_q, fl_d;
    logic             oc_mode, cap_hit, cmp_hit, ev;
    logic             sc_wr_en, sc_rd_en, clr_req;
    logic [CNT_W-1:0] val_r;
    logic             pin_r;

    // event generation
    always_comb begin
        oc_mode = ctl_q.buf_mode | ctl_q.cmp_mode;
        unique case (ctl_q.sel)
            SEL_RISE: cap_hit = rise;
            SEL_FALL: cap_hit = fall;
            SEL_BOTH: cap_hit = rise | fall;
            SEL_OFF:  cap_hit = 1'b0;
            default:  cap_hit = 1'b0;
        endcase
        cmp_hit  = (cnt == cmp_val);
        ev       = en & (oc_mode ? cmp_hit : cap_hit);
        sc_wr_en = en & sc_wr;
        sc_rd_en = en & sc_rd;
        clr_req  = sc_wr_en & ~wdata[SC_FLAG];
    end

    // flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= FL_IDLE;
        else        fl_q <= fl_d;
    end

    // flag transitions
    always_comb begin
        fl_d = fl_q;
        unique case (fl_q)
            FL_IDLE:  if (ev) fl_d = FL_PEND;
            FL_PEND:  if (!ev && sc_rd_en) fl_d = FL_ARMED;
            FL_ARMED: begin
                if (ev)           fl_d = FL_PEND;
                else if (clr_req) fl_d = FL_IDLE;
            end
            default:  fl_d = FL_IDLE;
        endcase
    end

    always_comb begin
        ctl_d.ie       = wdata[SC_IE];
        ctl_d.buf_mode = HAS_BUF & wdata[SC_BUF];
        ctl_d.cmp_mode = wdata[SC_CMP];
        ctl_d.sel      = wdata[SC_SELH:SC_SELL];
        ctl_d.spare1   = wdata[1];
        ctl_d.spare0   = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctl_q <= '0;
        else if (sc_wr_en) ctl_q <= ctl_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              val_r <= '0;
        else if (ev && !oc_mode) val_r <= cnt;
        else if (val_wr)         val_r <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_r <= 1'b0;
        end else if (ev && oc_mode) begin
            unique case (ctl_q.sel)
                SEL_RISE: pin_r <= ~pin_r;
                SEL_FALL: pin_r <= 1'b0;
                SEL_BOTH: pin_r <= 1'b1;
                SEL_OFF:  pin_r <= pin_r;
                default:  pin_r <= pin_r;
            endcase
        end
    end

    // outputs
    always_comb begin
        flag    = (fl_q != FL_IDLE);
        armed   = (fl_q == FL_ARMED);
        sc_q    = {flag, ctl_q};
        val_q   = val_r;
        irq     = flag & ctl_q.ie & en;
        pin_oe  = en & oc_mode & (ctl_q.sel != SEL_OFF);
        pin_out = pin_r;
        buf_q   = ctl_q.buf_mode;
        event_o = ev;
    end

endmodule

// File: rtl/tim_ccpair.sv
module tim_ccpair
    import tim_ccpair_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [1:0]       pin_in,
    output logic [1:0]       pin_out,
    output logic [1:0]       pin_oe,
    output logic [1:0]       irq
);
    localparam int NCH = 2;
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    logic [CNT_W-1:0]            cnt_q;
    logic [CNT_W-1:0]            cmp0_w;
    logic [NCH-1:0][7:0]         sc_w;
    logic [NCH-1:0][CNT_W-1:0]   val_w;
    logic [NCH-1:0]              rise_w, fall_w, flag_w, armed_w, ev_w, buf_w;
    logic [NCH-1:0]              en_w, sc_wr_w, sc_rd_w, val_wr_w;
    logic                        buf_on;

    // only channel 0 can hold the buffered bit
    assign buf_on = |buf_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    tim_buf_cmp #(.CNT_W(CNT_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .buffered (buf_on),
        .wrap     (cnt_q == CNT_LAST),
        .val0     (val_w[0]),
        .val1     (val_w[1]),
        .wr0      (val_wr_w[0]),
        .wr1      (val_wr_w[1]),
        .cmp_val  (cmp0_w)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            localparam logic [2:0] A_SC  = 3'(2 * g);
            localparam logic [2:0] A_VAL = 3'(2 * g + 1);

            assign sc_wr_w[g]  = bus_sel & bus_wr & (bus_addr == A_SC);
            assign sc_rd_w[g]  = bus_sel & bus_rd & (bus_addr == A_SC);
            assign val_wr_w[g] = bus_sel & bus_wr & (bus_addr == A_VAL);
            assign en_w[g]     = (g == 0) ? 1'b1 : ~buf_on;

            tim_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (pin_in[g]),
                .rise  (rise_w[g]),
                .fall  (fall_w[g])
            );

            tim_cc_chan #(.CNT_W(CNT_W), .HAS_BUF(g == 0)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en_w[g]),
                .cnt     (cnt_q),
                .cmp_val ((g == 0) ? cmp0_w : val_w[g]),
                .wdata   (bus_wdata),
                .sc_wr   (sc_wr_w[g]),
                .sc_rd   (sc_rd_w[g]),
                .val_wr  (val_wr_w[g]),
                .rise    (rise_w[g]),
                .fall    (fall_w[g]),
                .sc_q    (sc_w[g]),
                .val_q   (val_w[g]),
                .irq     (irq[g]),
                .pin_out (pin_out[g]),
                .pin_oe  (pin_oe[g]),
                .buf_q   (buf_w[g]),
                .armed   (armed_w[g]),
                .flag    (flag_w[g]),
                .event_o (ev_w[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            3'd0:    bus_rdata = CNT_W'(sc_w[0]);
            3'd1:    bus_rdata = val_w[0];
            3'd2:    bus_rdata = CNT_W'(sc_w[1]);
            3'd3:    bus_rdata = val_w[1];
            ADR_CNT: bus_rdata = cnt_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tim_ccpair_chk.sv
module tim_ccpair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic       bus_wdata7,
    input logic [1:0] flag,
    input logic [1:0] armed,
    input logic [1:0] ev,
    input logic [1:0] irq,
    input logic [1:0] pin_oe,
    input logic       buf_on
);
    // R3
    event_sets_flag0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> flag[0]);

    // R3
    event_sets_flag1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[1] |=> flag[1]);

    // R4
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag[0]) |-> ($past(armed[0]) && $past(bus_sel && bus_wr && bus_addr == 3'd0 && !bus_wdata7)));

    // R5
    no_lost_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed[0] && ev[0]) |=> (flag[0] && !armed[0]));

    // R6
    one_write_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag[0] && !ev[0] && bus_sel && bus_wr && bus_addr == 3'd0 && bus_wdata7) |=> !flag[0]);

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> flag[0]);

    // R9
    ch1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_on |-> (!irq[1] && !pin_oe[1]));

endmodule

bind tim_ccpair tim_ccpair_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata7 (bus_wdata[7]),
    .flag       (flag_w),
    .armed      (armed_w),
    .ev         (ev_w),
    .irq        (irq),
    .pin_oe     (pin_oe),
    .buf_on     (buf_on)
);

// File: tb/test_tim_ccpair.sv
module test_tim_ccpair;
    localparam int CLK_P = 10;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic [1:0]       pin_in = '0;
    logic [1:0]       pin_out, pin_oe, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    tim_ccpair #(.CNT_W(CNT_W)) i_tim_ccpair (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [CNT_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    // combinational look without a read strobe; call right after a negedge
    task automatic peek(input logic [2:0] a, output logic [CNT_W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cnt_below(input int lim);
        logic [CNT_W-1:0] c;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); peek(3'd4, c);
            if (c < lim) break;
        end
    endtask

    task automatic wait_cnt_atleast(input int lim);
        logic [CNT_W-1:0] c;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); peek(3'd4, c);
            if (c >= lim) break;
        end
    endtask

    task automatic t_reset;
        logic [CNT_W-1:0] d;
        check("R1 irq", irq, 2'b00);
        check("R1 pin_oe", pin_oe, 2'b00);
        check("R1 pin_out", pin_out, 2'b00);
        bus_read(3'd0, d); check("R1 sc0", d, 0);
        bus_read(3'd2, d); check("R1 sc1", d, 0);
        bus_read(3'd1, d); check("R1 val0", d, 0);
        bus_read(3'd3, d); check("R1 val1", d, 0);
    endtask

    task automatic t_capture0;
        logic [CNT_W-1:0] c, d, expv;
        bus_write(3'd0, 'h44);                       // IE, rising edge
        @(negedge clk); peek(3'd4, c); pin_in[0] = 1'b1;
        expv = c + 2;
        wait_cyc(2);
        check("R2 no flag before third edge", irq[0], 1'b0);
        wait_cyc(1);
        check("R2 rising capture flag", irq[0], 1'b1);
        peek(3'd1, d); check("R2 captured counter", d, expv);
        bus_write(3'd0, 'h44);
        wait_cyc(1);
        check("R4 zero write without read keeps flag", irq[0], 1'b1);
        bus_read(3'd0, d); check("R11 sc0 layout", d, 'hC4);
        bus_write(3'd0, 'h44);
        check("R4 read then zero write clears", irq[0], 1'b0);
        check("R7 irq drops with flag", irq[0], 1'b0);
        pin_in[0] = 1'b0; wait_cyc(5);
        check("R2 falling ignored in rise mode", irq[0], 1'b0);
        bus_write(3'd0, 'h4C);                       // either edge
        pin_in[0] = 1'b1; wait_cyc(4);
        check("R2 both-edge rising", irq[0], 1'b1);
        bus_read(3'd0, d);                           // arm
        pin_in[0] = 1'b0; wait_cyc(4);               // new event disarms
        bus_write(3'd0, 'h4C);
        check("R5 event between read and write keeps flag", irq[0], 1'b1);
        bus_read(3'd0, d);
        bus_write(3'd0, 'h4C);
        check("R5 fresh read allows clear", irq[0], 1'b0);
        bus_write(3'd0, 'hCC);
        wait_cyc(1);
        check("R6 write one does not set flag", irq[0], 1'b0);
        bus_read(3'd0, d); check("R6 other bits stored", d, 'h4C);
        bus_write(3'd0, 'h40);                       // capture off
        pin_in[0] = 1'b1; wait_cyc(4);
        check("R2 select 00 no rise capture", irq[0], 1'b0);
        pin_in[0] = 1'b0; wait_cyc(4);
        check("R2 select 00 no fall capture", irq[0], 1'b0);
    endtask

    task automatic t_capture1;
        logic [CNT_W-1:0] d;
        bus_write(3'd2, 'h08);                       // falling, IE off
        pin_in[1] = 1'b1; wait_cyc(5);
        bus_read(3'd2, d); check("R2 ch1 rising ignored", d, 'h08);
        pin_in[1] = 1'b0; wait_cyc(4);
        bus_read(3'd2, d); check("R2 ch1 falling capture", d, 'h88);
        check("R7 no irq with enable off", irq[1], 1'b0);
        bus_write(3'd2, 'hE8);                       // flag 1 no effect, IE on, bit5 reserved
        wait_cyc(1);
        check("R7 irq with flag and enable", irq[1], 1'b1);
        bus_read(3'd2, d); check("R9 ch1 bit5 reads 0", d, 'hC8);
    endtask

    task automatic t_compare(input logic [1:0] sel, input logic exp_pin);
        logic [CNT_W-1:0] c, d;
        bus_read(3'd0, d);
        bus_write(3'd0, CNT_W'(8'h50) | CNT_W'({sel, 2'b00}));
        check("R8 pin_oe in compare", pin_oe[0], 1'b1);
        @(negedge clk); peek(3'd4, c);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = c + 20;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        wait_cyc(19);
        check("R3 no flag before match", irq[0], 1'b0);
        wait_cyc(1);
        check("R3 flag on match", irq[0], 1'b1);
        check("R8 pin action", pin_out[0], exp_pin);
    endtask

    task automatic t_buffered;
        logic [CNT_W-1:0] c, d, x;
        bus_read(3'd0, d);
        bus_write(3'd0, 'h50);
        check("R7 ch1 irq before buffered", irq[1], 1'b1);
        wait_cnt_below(100);
        bus_write(3'd1, 600);
        bus_write(3'd0, 'h64);                       // IE, buffered, toggle
        check("R9 ch1 irq held off", irq[1], 1'b0);
        check("R9 ch1 pin released", pin_oe[1], 1'b0);
        bus_write(3'd2, 'h00);
        bus_read(3'd2, d); check("R9 ch1 control write ignored", d, 'hC8);
        @(negedge clk); peek(3'd4, c);
        x = c + 30;
        bus_write(3'd3, x);
        wait_cyc(60);
        check("R10 new value not used before wrap", irq[0], 1'b0);
        wait_cnt_atleast(700);
        check("R10 active value used until wrap", irq[0], 1'b1);
        bus_read(3'd0, d);
        bus_write(3'd0, 'h64);
        wait_cnt_atleast(1000);
        check("R10 no match late in period", irq[0], 1'b0);
        wait_cnt_below(10);
        wait_cnt_atleast(int'(x) + 5);
        check("R10 last written value loaded at wrap", irq[0], 1'b1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_capture0();
        t_capture1();
        t_compare(2'b01, 1'b1);
        t_compare(2'b10, 1'b0);
        t_compare(2'b11, 1'b1);
        t_compare(2'b01, 1'b0);
        t_buffered();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule